// File: doc/BRIEF.md
# Programmable Management Clock Generator

This block derives the management data clock (MDC) for a PHY management interface from the system clock. Software writes a speed value into a small control register. Each half period of MDC lasts twice that value in system clocks, so the full period is four times the speed value. For example, a 50 MHz system clock with a speed of 5 gives a 2.5 MHz MDC. Writing a speed of zero stops the clock. A status output tells the frame serializer whether a management read or write frame may be started.

The core is a three-state machine that also drives MDC: MDC_IDLE (MDC low, no counting), MDC_HIGH and MDC_LOW. Its transitions are:

- **start** (MDC_IDLE to MDC_HIGH) happens when the speed becomes non-zero.
- **fall** (MDC_HIGH to MDC_LOW) and **rise** (MDC_LOW to MDC_HIGH) happen when the half-period counter reaches terminal count while the speed is non-zero.
- **park_hi** (MDC_HIGH to MDC_IDLE) and **park_lo** (MDC_LOW to MDC_IDLE) happen at terminal count while the speed is zero.
- **hold** means the machine stays in its state in every other case.

The speed value is sampled only when the machine enters a phase, so a new divisor never cuts a phase short.

Top module: `mdc_clock_gen`

## Requirements
- R1: After reset the control register reads 0x0000_0000, mdc is low and frame_ok is low, and mdc stays low until a non-zero speed is written.
- R2: The speed field is 6 bits at register bits 6:1. Bit 0 and bits 31:7 always read as zero and ignore writes. Writing 0x0000_000A reads back 0x0000_000A (speed 5), and writing 0xFFFF_FFFF reads back 0x0000_007E.
- R3: In steady operation with speed S, every high phase and every low phase of mdc lasts exactly 2*S system clocks, for S from 1 to 63.
- R4: frame_ok is high exactly when the stored speed is non-zero, and it takes its new value in the cycle after the write.
- R5: When a non-zero speed is written while MDC is idle, mdc goes high on the clock edge that follows the write edge.
- R6: A speed change written during a phase does not change that phase's length. The phases after the next mdc edge use the new speed.
- R7: Writing zero during a high phase lets that phase complete at full length. mdc then goes low and stays low.
- R8: mdc is a registered output and changes only at the end of a counted phase, or on the start transition out of idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Register write data |
| rd_data | output | 32 | Register read data, the speed field in bits 6:1 |
| mdc | output | 1 | Management data clock |
| frame_ok | output | 1 | High when management frames may be started |

## Verification
The hardest situation to reach is a write that lands partway through a phase. The bench has to show that the phase already running keeps its old length while the following phases take the new one. The same applies to writing zero during a high phase: the bench has to show the phase finishing in full before MDC parks low. The bench gets there by counting the phase while it runs and issuing the register write at a chosen sample inside it. It then goes on counting that phase and the next ones sample by sample.

// File: rtl/mdcgen_pkg.sv
package mdcgen_pkg;
    typedef enum logic [1:0] {
        MDC_IDLE = 2'd0,
        MDC_HIGH = 2'd1,
        MDC_LOW  = 2'd2
    } mdc_state_e;
endpackage

// File: rtl/mdcgen_speed_reg.sv
module mdcgen_speed_reg #(
    parameter int REG_W     = 32,
    parameter int SPEED_W   = 6,
    parameter int SPEED_LSB = 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [REG_W-1:0]   wr_data,
    output logic [SPEED_W-1:0] speed,
    output logic [REG_W-1:0]   rd_data
);
    // Only the speed field is stored; every other bit is constant zero.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            speed <= '0;
        end else if (wr_en) begin
            speed <= wr_data[SPEED_LSB +: SPEED_W];
        end
    end

    always_comb begin
        rd_data = '0;
        rd_data[SPEED_LSB +: SPEED_W] = speed;
    end
endmodule

// File: rtl/mdcgen_half_cnt.sv
module mdcgen_half_cnt #(
    parameter int SPEED_W = 6,
    localparam int CNT_W  = SPEED_W + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [SPEED_W-1:0] speed,
    output logic [CNT_W-1:0]   cnt,
    output logic               tc
);
    // On load the counter takes 2*speed-1, so a phase spans 2*speed clocks.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= {speed, 1'b0} - CNT_W'(1);
        end else if (cnt != '0) begin
            cnt <= cnt - CNT_W'(1);
        end
    end

    assign tc = (cnt == '0);
endmodule

// File: rtl/mdcgen_fsm.sv
module mdcgen_fsm
    import mdcgen_pkg::*;
#(
    parameter int SPEED_W = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [SPEED_W-1:0] speed,
    input  logic               tc,
    output mdc_state_e         state,
    output logic               load,
    output logic               mdc
);
    mdc_state_e state_nx;
    logic       enabled;

    assign enabled = (speed != '0);

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= MDC_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // Transitions: start, fall, rise, park_hi, park_lo, hold.
    always_comb begin
        state_nx = state;
        unique case (state)
            MDC_IDLE: if (enabled) state_nx = MDC_HIGH;
            MDC_HIGH: if (tc)      state_nx = enabled ? MDC_LOW  : MDC_IDLE;
            MDC_LOW:  if (tc)      state_nx = enabled ? MDC_HIGH : MDC_IDLE;
            default:               state_nx = MDC_IDLE;
        endcase
    end

    // Outputs: the counter reloads on every entry into a counted phase.
    always_comb begin
        load = (state_nx != MDC_IDLE) && (state_nx != state);
        mdc  = (state == MDC_HIGH);
    end
endmodule

// File: rtl/mdc_clock_gen.sv
module mdc_clock_gen
    import mdcgen_pkg::*;
#(
    parameter int REG_W     = 32,
    parameter int SPEED_W   = 6,
    parameter int SPEED_LSB = 1,
    localparam int CNT_W    = SPEED_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    output logic             mdc,
    output logic             frame_ok
);
    logic [SPEED_W-1:0] speed_q;
    logic [CNT_W-1:0]   cnt_q;
    logic               cnt_tc;
    logic               cnt_load;
    mdc_state_e         fsm_state;

    mdcgen_speed_reg #(
        .REG_W    (REG_W),
        .SPEED_W  (SPEED_W),
        .SPEED_LSB(SPEED_LSB)
    ) u_reg (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_data(wr_data),
        .speed  (speed_q),
        .rd_data(rd_data)
    );

    mdcgen_half_cnt #(.SPEED_W(SPEED_W)) u_cnt (
        .clk  (clk),
        .rst_n(rst_n),
        .load (cnt_load),
        .speed(speed_q),
        .cnt  (cnt_q),
        .tc   (cnt_tc)
    );

    mdcgen_fsm #(.SPEED_W(SPEED_W)) u_fsm (
        .clk  (clk),
        .rst_n(rst_n),
        .speed(speed_q),
        .tc   (cnt_tc),
        .state(fsm_state),
        .load (cnt_load),
        .mdc  (mdc)
    );

    assign frame_ok = (speed_q != '0);
endmodule

// File: rtl/mdcgen_chk.sv
module mdcgen_chk #(
    parameter int REG_W     = 32,
    parameter int SPEED_W   = 6,
    parameter int SPEED_LSB = 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [REG_W-1:0] wr_data,
    input logic [REG_W-1:0] rd_data,
    input logic             mdc,
    input logic             frame_ok,
    input logic             cnt_tc
);
    localparam logic [REG_W-1:0] FIELD_MASK = ((REG_W'(1) << SPEED_W) - REG_W'(1)) << SPEED_LSB;

    assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data & ~FIELD_MASK) == '0);

    assert_write_sets_ok_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (frame_ok == ($past(wr_data[SPEED_LSB +: SPEED_W]) != '0)));

    assert_parked_stays_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_ok && !mdc) |=> !mdc);

    assert_edge_at_terminal_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mdc) |-> $past(cnt_tc));

    assert_low_out_of_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mdc) |-> $past(frame_ok));
endmodule

bind mdc_clock_gen mdcgen_chk #(
    .REG_W    (REG_W),
    .SPEED_W  (SPEED_W),
    .SPEED_LSB(SPEED_LSB)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .rd_data (rd_data),
    .mdc     (mdc),
    .frame_ok(frame_ok),
    .cnt_tc  (cnt_tc)
);

// File: tb/tb_mdc_clock_gen.sv
`timescale 1ns/1ps
module tb_mdc_clock_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        mdc;
    logic        frame_ok;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    localparam int NVEC = 6;
    localparam int VEC_SPEED [NVEC] = '{1, 3, 4, 5, 7, 63};
    localparam int VEC_HALF  [NVEC] = '{2, 6, 8, 10, 14, 126};

    always #2 clk = ~clk;

    mdc_clock_gen dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .mdc(mdc), .frame_ok(frame_ok)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic write_reg(input logic [31:0] v);
        wr_en = 1'b1; wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_rise(output int n);
        logic prev = mdc;
        n = -1;
        for (int i = 1; i <= 2000; i++) begin
            @(negedge clk);
            if (!prev && mdc) begin n = i; return; end
            prev = mdc;
        end
    endtask

    // Count samples while mdc holds lvl; optionally write wv at sample wr_at.
    task automatic count_level(input logic lvl, input int wr_at, input logic [31:0] wv, output int n);
        n = 0;
        while (mdc === lvl && n < 1000) begin
            if (n == wr_at) begin wr_en = 1'b1; wr_data = wv; end
            else wr_en = 1'b0;
            n++;
            @(negedge clk);
        end
        wr_en = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
            $finish;
        end
    end

    initial begin
        int n, hi, lo;
        bit stayed_low;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(rd_data == 32'h0, "R1 reg", rd_data, 0);
        check(mdc == 1'b0, "R1 mdc", mdc, 0);
        check(frame_ok == 1'b0, "R1 frame_ok", frame_ok, 0);
        stayed_low = 1'b1;
        repeat (20) begin @(negedge clk); if (mdc) stayed_low = 1'b0; end
        check(stayed_low, "R1 idle low", !stayed_low, 0);

        // R2 register format, R5 start latency, R4 frame_ok
        write_reg(32'hFFFF_FFFF);
        check(rd_data == 32'h7E, "R2 reserved bits", rd_data, 32'h7E);
        check(frame_ok == 1'b1, "R4 frame_ok after write", frame_ok, 1);
        write_reg(32'h0);
        repeat (200) @(negedge clk);
        check(mdc == 1'b0, "R7 parked", mdc, 0);
        write_reg(32'h0000_000A);
        check(rd_data == 32'h0000_000A, "R2 readback", rd_data, 32'hA);
        wait_rise(n);
        check(n == 1, "R5 start latency", n, 1);
        count_level(1'b1, -1, '0, hi);
        check(hi == 10, "R5 first high", hi, 10);

        // R3 vector table of divisors
        for (int v = 0; v < NVEC; v++) begin
            write_reg(32'(VEC_SPEED[v] << 1));
            wait_rise(n);
            wait_rise(n);
            count_level(1'b1, -1, '0, hi);
            count_level(1'b0, -1, '0, lo);
            check(hi == VEC_HALF[v], $sformatf("R3 high speed %0d", VEC_SPEED[v]), hi, VEC_HALF[v]);
            check(lo == VEC_HALF[v], $sformatf("R3 low speed %0d", VEC_SPEED[v]), lo, VEC_HALF[v]);
        end

        // R6 change mid-phase: 3 -> 5 written inside a high phase
        write_reg(32'h6);
        wait_rise(n);
        wait_rise(n);
        count_level(1'b1, 1, 32'hA, hi);
        count_level(1'b0, -1, '0, lo);
        check(hi == 6, "R6 running phase keeps old length", hi, 6);
        check(lo == 10, "R6 next low uses new speed", lo, 10);
        count_level(1'b1, -1, '0, hi);
        check(hi == 10, "R6 next high uses new speed", hi, 10);

        // R7 disable inside a high phase
        write_reg(32'h6);
        wait_rise(n);
        wait_rise(n);
        count_level(1'b1, 1, 32'h0, hi);
        check(hi == 6, "R7 phase completes", hi, 6);
        check(frame_ok == 1'b0, "R4 frame_ok cleared", frame_ok, 0);
        stayed_low = 1'b1;
        repeat (60) begin @(negedge clk); if (mdc) stayed_low = 1'b0; end
        check(stayed_low, "R7 stays low", !stayed_low, 0);

        // R5 re-enable from zero
        write_reg(32'hE);
        wait_rise(n);
        check(n == 1, "R5 restart latency", n, 1);
        count_level(1'b1, -1, '0, hi);
        count_level(1'b0, -1, '0, lo);
        check(hi == 14 && lo == 14, "R3 after restart", hi * 1000 + lo, 14014);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end
endmodule